// File: doc/BRIEF.md
# Selectable Carrier Modulator for Port Outputs

This block produces a 38 kHz square-wave carrier from the system clock and combines it with the levels that software writes to eight port pins. Each pin can either pass its written level through unchanged or carry that level exclusive-ORed with the carrier. A serial transmit line routed through a selected pin is therefore turned into infrared bursts directly: while the line sits low, the pin toggles at the carrier rate.

The carrier comes from a half-period counter and a two-state machine. The machine has the states `CAR_LOW` and `CAR_HIGH`. On the cycle the counter reaches its last value, the counter wraps and the machine takes one of two transitions: `CAR_LOW -> CAR_HIGH` or `CAR_HIGH -> CAR_LOW`. On every other cycle the machine stays where it is. The divider keeps running whether or not modulation is enabled. A register write port holds two values. The first is an 8-bit pin-select mask at address 0x9F. The second is a global enable, which is bit 0 of a configuration register at address 0xA8.

Top module: `ir_carrier_mod`

## Requirements
- R1: While reset is asserted and right after it, the select mask and the enable are 0, and every `pin_drv` bit equals the matching `pin_lvl` bit.
- R2: After reset the carrier is 0 for HALF clock edges, then 1 for HALF edges, and repeats. HALF is CLK_HZ/(2*CARRIER_HZ), so the duty cycle is 50%.
- R3: When the enable is 1 and select bit i is 1, `pin_drv[i]` equals `pin_lvl[i]` XOR carrier, with no clock of latency from `pin_lvl`.
- R4: When the enable is 0 or select bit i is 0, `pin_drv[i]` equals `pin_lvl[i]`.
- R5: A write with `wr_en`=1 to address 0x9F loads `wr_data` into the select mask. The new mask takes effect from the next clock edge.
- R6: A write to address 0xA8 loads the enable from `wr_data` bit 0. The other data bits have no effect.
- R7: Writes to any other address, and cycles with `wr_en`=0, leave both the mask and the enable unchanged.
- R8: The carrier divider keeps counting while modulation is disabled. When modulation is enabled again, the carrier continues in the phase it would have had if it had never been disabled.
- R9: A modulated pin whose written level is 0 outputs the carrier itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pin_lvl | input | 8 | Levels written to the eight pins |
| pin_drv | output | 8 | Drive levels for the eight pins |

## Verification
The written levels are tried in three groups. All-zero levels expose the raw carrier on every selected pin and so measure its period and phase. All-one levels show the inverted carrier. Mixed patterns such as 0x3C and 0xA5 show that selected and unselected pins are kept apart bit by bit.

Select masks are tried as full, half and walking-one values. These separate per-pin gating from the global enable. Writes with stray data bits, writes to wrong addresses, and writes with the strobe low are checked for their lack of effect. Disabling and then re-enabling modulation in the middle of a carrier period shows that the phase continues rather than restarting.

// File: rtl/ir_mod_pkg.sv
package ir_mod_pkg;

    typedef enum logic {
        CAR_LOW  = 1'b0,
        CAR_HIGH = 1'b1
    } car_state_e;

    function automatic int unsigned half_count(input int unsigned clk_hz,
                                               input int unsigned car_hz);
        int unsigned h;
        h = clk_hz / (2 * car_hz);
        return (h < 1) ? 1 : h;
    endfunction

endpackage

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ir_mod_pkg::*;
#(
    parameter int unsigned HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic carrier
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;
    car_state_e    state_q, state_d;

    assign wrap = (cnt_q == LAST);

    // half-period counter, free running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAR_LOW:  if (wrap) state_d = CAR_HIGH;
            CAR_HIGH: if (wrap) state_d = CAR_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAR_LOW;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            CAR_LOW:  carrier = 1'b0;
            CAR_HIGH: carrier = 1'b1;
        endcase
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2
    toggle_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (carrier != $past(carrier)));

    // R2
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(carrier));

endmodule

// File: rtl/ir_mod_regs.sv
module ir_mod_regs #(
    parameter int unsigned NPINS    = 8,
    parameter int unsigned AW       = 8,
    parameter logic [AW-1:0] SEL_ADDR = 8'h9F,
    parameter logic [AW-1:0] CFG_ADDR = 8'hA8,
    parameter int unsigned EN_BIT   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] sel_q,
    output logic             en_q
);
    logic hit_sel, hit_cfg;

    assign hit_sel = wr_en && (wr_addr == SEL_ADDR);
    assign hit_cfg = wr_en && (wr_addr == CFG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sel_q <= '0;
        else if (hit_sel) sel_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (hit_cfg) en_q <= wr_data[EN_BIT];
    end

    // R5
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_ADDR) |=> (sel_q == $past(wr_data)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(sel_q) && $stable(en_q)));

endmodule

// File: rtl/ir_pin_mixer.sv
module ir_pin_mixer #(
    parameter int unsigned NPINS = 8
) (
    input  logic             carrier,
    input  logic             en,
    input  logic [NPINS-1:0] sel,
    input  logic [NPINS-1:0] pin_lvl,
    output logic [NPINS-1:0] pin_drv
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic apply;
        assign apply      = en & sel[i];
        assign pin_drv[i] = pin_lvl[i] ^ (apply & carrier);
    end
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod
    import ir_mod_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 250_000_000,
    parameter int unsigned CARRIER_HZ = 38_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] pin_lvl,
    output logic [7:0] pin_drv
);
    localparam int unsigned NPINS = 8;
    localparam int unsigned HALF  = half_count(CLK_HZ, CARRIER_HZ);

    logic             carrier;
    logic [NPINS-1:0] sel_q;
    logic             en_q;

    ir_carrier_gen #(.HALF(HALF)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .carrier (carrier)
    );

    ir_mod_regs #(.NPINS(NPINS), .AW(8)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel_q   (sel_q),
        .en_q    (en_q)
    );

    ir_pin_mixer #(.NPINS(NPINS)) u_mix (
        .carrier (carrier),
        .en      (en_q),
        .sel     (sel_q),
        .pin_lvl (pin_lvl),
        .pin_drv (pin_drv)
    );

    // R4
    pass_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (pin_drv == pin_lvl));

    // R9
    zero_gives_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && sel_q[0] && !pin_lvl[0]) |-> (pin_drv[0] == carrier));

endmodule

// File: tb/tb_ir_carrier_mod.sv
module tb_ir_carrier_mod;
    localparam int HALF     = 10;
    localparam int CLK_HZ   = 760_000;
    localparam logic [7:0] SEL_A = 8'h9F;
    localparam logic [7:0] CFG_A = 8'hA8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pin_lvl = '0;
    logic [7:0] pin_drv;

    int  n_vec = 0;
    int  n_bad = 0;
    int  k = 0;
    bit  m_en = 0;
    logic [7:0] m_sel = '0;
    bit  done = 0;

    always #2 clk = ~clk;

    ir_carrier_mod #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(38_000)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_lvl(pin_lvl), .pin_drv(pin_drv)
    );

    function automatic bit car_model();
        return ((k / HALF) % 2) == 1;
    endfunction

    task automatic compare(input string tag);
        logic [7:0] exp;
        bit c;
        c = car_model();
        for (int i = 0; i < 8; i++)
            exp[i] = pin_lvl[i] ^ (c & m_en & m_sel[i]);
        n_vec++;
        if (pin_drv !== exp) begin
            n_bad++;
            $display("FAIL %s: pin_drv=%02h expected %02h (k=%0d)", tag, pin_drv, exp, k);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        if (rst_n) begin
            k++;
            if (wr_en && wr_addr == SEL_A)      m_sel = wr_data;
            else if (wr_en && wr_addr == CFG_A) m_en  = wr_data[0];
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic write(input logic [7:0] a, input logic [7:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(tag);
        wr_en = 1'b0;
        step(tag);
    endtask

    initial begin
        pin_lvl = 8'hA5;
        @(negedge clk);
        compare("R1");
        run(2, "R1");
        rst_n = 1'b1;
        run(3, "R1");
        // mask loaded while disabled: pass-through, divider running
        write(SEL_A, 8'hFF, "R5");
        pin_lvl = 8'h00; run(25, "R4");
        pin_lvl = 8'hFF; run(25, "R4");
        pin_lvl = 8'h5A; run(13, "R8");
        // stray bits without bit 0 keep it disabled
        write(CFG_A, 8'hFE, "R6");
        pin_lvl = 8'h00; run(12, "R6");
        write(CFG_A, 8'h01, "R6");
        run(45, "R9");
        pin_lvl = 8'hFF; run(25, "R3");
        pin_lvl = 8'h3C; run(25, "R3");
        write(SEL_A, 8'h0F, "R5");
        pin_lvl = 8'h00; run(30, "R4");
        // ignored writes
        write(8'h9E, 8'h00, "R7");
        write(8'hA9, 8'h00, "R7");
        wr_addr = SEL_A; wr_data = 8'h00; run(15, "R7");
        wr_addr = CFG_A; run(7, "R7");
        // disable mid-period, re-enable: phase continues
        write(CFG_A, 8'h00, "R8");
        run(17, "R8");
        write(CFG_A, 8'h03, "R8");
        run(30, "R8");
        // walking select bit
        for (int b = 0; b < 8; b++) begin
            write(SEL_A, 8'(1 << b), "R5");
            pin_lvl = 8'hA5; run(11, "R3");
        end
        run(40, "R2");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule